// File: doc/BRIEF.md
# Interrupt Selection and CPU Priority Slice

This block holds the state of a parameterised set of interrupt sources and the interface registers of one processor. Each source carries an enable, a pending flag, an active flag, a group bit, a per-processor target mask and an 8-bit priority, where a lower number is more urgent. Every cycle the block scans all sources and picks the best candidate for its processor. It raises its interrupt line when the group priority of that candidate beats the current running priority and the processor interface is enabled.

Software or a neighbouring block configures sources through a plain write port and marks sources pending through a pend strobe. The processor takes an interrupt with an acknowledge strobe and completes it with an end-of-interrupt strobe. A small register port reads and writes the binary point and reads the running priority. A secure attribute on each access chooses between the secure view, which is the primary binary point, and the non-secure view, which is an aliased copy or, in shared mode, a view derived from the primary one. There is no streaming data path. Every pin is a level or a one-cycle strobe with no back-pressure, and each strobe takes effect at the next rising clock edge.

Top module: `irq_cpu_slice`

## Requirements
- R1: After reset no source is enabled, pending or active. The running priority is idle (internal value 0x100), the interrupt line is low, `ack_id` shows 1023, the primary binary point equals BPR_MIN (default 2) and the aliased copy equals ABPR_MIN (default 3).
- R2: When no source qualifies, `ack_id` is 1023, which is the spurious ID.
- R3: A source qualifies only when it is enabled, pending and not active, and its ID is below INTERNAL_LIMIT (default 32) or bit CPU_IDX of its target mask is set.
- R4: Among the qualifying sources, the lowest raw priority value wins. A tie goes to the lower ID. `ack_id` shows the winner.
- R5: The group priority is the priority ANDed with the 8-bit mask `0xFF << (b+1)`. For a group-1 source while `cbpr` is 0, b is the aliased binary point minus one. In all other cases b is the primary binary point.
- R6: `irq_out` is high exactly when `cpu_en` is 1, a source qualifies, and the winner's group priority is numerically below the running priority.
- R7: An `ack` pulse while a source qualifies makes the winner active, clears its pending flag and loads the winner's group priority as the running priority. With no qualifying source, `ack` changes nothing.
- R8: An `eoi` pulse clears the active flag of source `eoi_id` and returns the running priority to idle.
- R9: Reading the running priority (`reg_sel`=1) returns 0xFF while the processor is idle when LEGACY_REV is 0. Otherwise it returns the low byte of the running priority.
- R10: A read of the binary point (`reg_sel`=0) returns the primary value when `reg_secure`=1. A non-secure read returns the aliased copy when `cbpr` is 0, and the primary value plus one, saturated at 7, when `cbpr` is 1.
- R11: A non-secure binary-point write is ignored when `cbpr` is 1. Otherwise it stores `max(reg_wdata[2:0], ABPR_MIN)` into the aliased copy.
- R12: A secure binary-point write stores `max(reg_wdata[2:0], BPR_MIN)` into the primary binary point.
- R13: A source that is pending again while it is still active is never selected, until `eoi` clears its active flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_en | input | 1 | Processor interface enable |
| cbpr | input | 1 | Shared binary-point mode |
| cfg_we | input | 1 | Source configuration write strobe |
| cfg_id | input | SRC_W | Source being configured |
| cfg_enable | input | 1 | New enable bit |
| cfg_group | input | 1 | New group bit (1 = group 1) |
| cfg_prio | input | 8 | New priority |
| cfg_targets | input | NUM_CPU | New target mask |
| pend_set | input | 1 | Mark source `pend_id` pending |
| pend_id | input | SRC_W | Source to mark pending |
| ack | input | 1 | Acknowledge strobe |
| ack_id | output | 10 | Currently selected ID, 1023 if none |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_id | input | SRC_W | Source being completed |
| irq_out | output | 1 | Interrupt request to the processor |
| reg_sel | input | 1 | 0 = binary point, 1 = running priority |
| reg_secure | input | 1 | Secure attribute of the access |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
The selector is tried with sources that fail one qualification condition at a time: disabled, not pending, active, or external with a foreign target mask. Each case shows which condition the design enforces. Equal priorities on two IDs separate a strict less-than from a less-or-equal compare. A re-pend during service separates the active filter from a plain pending check. Group-1 sources are taken with `cbpr` both clear and set, and the loaded running priority exposes which binary point was used and whether the minus-one adjustment happened. Random writes of binary-point values in both security views and both modes then catch clamping, saturation and the ignored write against a bench model.

// File: rtl/irq_slice_pkg.sv
package irq_slice_pkg;
  typedef logic [7:0] prio_t;
  typedef logic [2:0] bp_t;
  typedef enum logic {REG_BINPT = 1'b0, REG_RUNPRI = 1'b1} reg_sel_e;

  localparam logic [9:0] SPURIOUS_ID = 10'd1023;
  localparam logic [8:0] IDLE_RUN    = 9'h100;

  // keep only the priority bits above binary point b
  function automatic prio_t group_mask(prio_t p, bp_t b);
    logic [8:0] m;
    m = 9'h0FF << ({1'b0, b} + 4'd1);
    return p & m[7:0];
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_slice_pkg::*;
#(
  parameter int NUM_SRC        = 48,
  parameter int NUM_CPU        = 8,
  parameter int INTERNAL_LIMIT = 32,
  parameter int CPU_IDX        = 0,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [SRC_W-1:0]                cfg_id,
  input  logic                            cfg_enable,
  input  logic                            cfg_group,
  input  prio_t                           cfg_prio,
  input  logic [NUM_CPU-1:0]              cfg_targets,
  input  logic                            pend_set,
  input  logic [SRC_W-1:0]                pend_id,
  input  logic                            ack_en,
  input  logic [SRC_W-1:0]                ack_idx,
  input  logic                            eoi_en,
  input  logic [SRC_W-1:0]                eoi_idx,
  output logic [NUM_SRC-1:0]              qualify,
  output logic [NUM_SRC-1:0]              group_o,
  output logic [NUM_SRC-1:0][7:0]         prio_o
);
  logic [NUM_SRC-1:0]              en_q, pend_q, act_q, grp_q;
  logic [NUM_SRC-1:0][7:0]         pri_q;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] tgt_q;
  logic [NUM_SRC-1:0]              reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; pend_q <= '0; act_q <= '0; grp_q <= '0;
      pri_q <= '0; tgt_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (cfg_we && cfg_id == SRC_W'(i)) begin
          en_q[i]  <= cfg_enable;
          grp_q[i] <= cfg_group;
          pri_q[i] <= cfg_prio;
          tgt_q[i] <= cfg_targets;
        end
        // a fresh pend in the same cycle as the ack survives it
        if (pend_set && pend_id == SRC_W'(i))     pend_q[i] <= 1'b1;
        else if (ack_en && ack_idx == SRC_W'(i)) pend_q[i] <= 1'b0;
        if (ack_en && ack_idx == SRC_W'(i))      act_q[i] <= 1'b1;
        else if (eoi_en && eoi_idx == SRC_W'(i)) act_q[i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_reach
    if (g < INTERNAL_LIMIT) begin : g_int
      assign reach[g] = 1'b1;
    end else begin : g_ext
      assign reach[g] = tgt_q[g][CPU_IDX];
    end
  end

  assign qualify = en_q & pend_q & ~act_q & reach;
  assign group_o = grp_q;
  assign prio_o  = pri_q;

  // R7: the acknowledged source becomes active and stops pending
  assert_ack_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !(pend_set && pend_id == ack_idx)) |=>
      (act_q[$past(ack_idx)] && !pend_q[$past(ack_idx)]));
  // R8: completion drops the active flag
  assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_en && !(ack_en && ack_idx == eoi_idx)) |=> !act_q[$past(eoi_idx)]);
  // R13: an active source never qualifies
  assert_no_active_pick_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (qualify & act_q) == '0);
endmodule

// File: rtl/irq_best_pick.sv
module irq_best_pick
  import irq_slice_pkg::*;
#(
  parameter int NUM_SRC = 48,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      qualify,
  input  logic [NUM_SRC-1:0]      group_i,
  input  logic [NUM_SRC-1:0][7:0] prio_i,
  input  bp_t                     bp,
  input  bp_t                     abp,
  input  logic                    cbpr,
  output logic                    best_valid,
  output logic [SRC_W-1:0]        best_idx,
  output prio_t                   best_gprio
);
  prio_t best_raw;
  bp_t   eff_bp;

  // ascending scan, replace only on a strictly lower value
  always_comb begin
    best_valid = 1'b0;
    best_idx   = '0;
    best_raw   = 8'hFF;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (qualify[i] && (!best_valid || prio_i[i] < best_raw)) begin
        best_valid = 1'b1;
        best_idx   = SRC_W'(i);
        best_raw   = prio_i[i];
      end
    end
  end

  assign eff_bp     = (group_i[best_idx] && !cbpr) ? (abp - 3'd1) : bp;
  assign best_gprio = group_mask(best_raw, eff_bp);

  // R5: masking only removes low bits, never raises the value
  assert_gprio_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> (best_gprio <= prio_i[best_idx] && best_gprio[0] == 1'b0));
  // R4: the winner itself qualifies
  assert_winner_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> qualify[best_idx]);
endmodule

// File: rtl/irq_binpt_regs.sv
module irq_binpt_regs
  import irq_slice_pkg::*;
#(
  parameter int BPR_MIN  = 2,
  parameter int ABPR_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic secure,
  input  logic cbpr,
  input  bp_t  wdata,
  output bp_t  bp_q,
  output bp_t  abp_q,
  output bp_t  ns_view
);
  localparam bp_t BP_FLOOR  = bp_t'(BPR_MIN);
  localparam bp_t ABP_FLOOR = bp_t'(ABPR_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q  <= BP_FLOOR;
      abp_q <= ABP_FLOOR;
    end else if (wr_en) begin
      if (secure)     bp_q  <= (wdata < BP_FLOOR)  ? BP_FLOOR  : wdata;
      else if (!cbpr) abp_q <= (wdata < ABP_FLOOR) ? ABP_FLOOR : wdata;
    end
  end

  assign ns_view = cbpr ? ((bp_q == 3'd7) ? 3'd7 : bp_q + 3'd1) : abp_q;

  // R11: non-secure write in shared mode leaves both copies untouched
  assert_ns_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !secure && cbpr) |=> ($stable(abp_q) && $stable(bp_q)));
  // R12: secure write at or above the floor lands verbatim
  assert_sec_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && secure && wdata >= BP_FLOOR) |=> bp_q == $past(wdata));
  // R11: the aliased copy never drops below one, so minus one cannot wrap
  assert_abp_floor_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abp_q >= ABP_FLOOR && abp_q != 3'd0);
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice
  import irq_slice_pkg::*;
#(
  parameter int NUM_SRC        = 48,
  parameter int NUM_CPU        = 8,
  parameter int INTERNAL_LIMIT = 32,
  parameter int CPU_IDX        = 0,
  parameter int BPR_MIN        = 2,
  parameter int ABPR_MIN       = 3,
  parameter bit LEGACY_REV     = 1'b0,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_en,
  input  logic               cbpr,
  input  logic               cfg_we,
  input  logic [SRC_W-1:0]   cfg_id,
  input  logic               cfg_enable,
  input  logic               cfg_group,
  input  logic [7:0]         cfg_prio,
  input  logic [NUM_CPU-1:0] cfg_targets,
  input  logic               pend_set,
  input  logic [SRC_W-1:0]   pend_id,
  input  logic               ack,
  output logic [9:0]         ack_id,
  input  logic               eoi,
  input  logic [SRC_W-1:0]   eoi_id,
  output logic               irq_out,
  input  logic               reg_sel,
  input  logic               reg_secure,
  input  logic               reg_we,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata
);
  logic [NUM_SRC-1:0]      qualify, group_v;
  logic [NUM_SRC-1:0][7:0] prio_v;
  logic                    best_valid, ack_fire, bp_we;
  logic [SRC_W-1:0]        best_idx;
  prio_t                   best_gprio, rpr_view;
  bp_t                     bp_q, abp_q, ns_view;
  logic [8:0]              running_q;

  assign ack_fire = ack && best_valid;
  assign bp_we    = reg_we && (reg_sel == REG_BINPT);

  irq_src_bank #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU),
    .INTERNAL_LIMIT(INTERNAL_LIMIT), .CPU_IDX(CPU_IDX)
  ) bank_i (
    .clk, .rst_n, .cfg_we, .cfg_id, .cfg_enable, .cfg_group, .cfg_prio,
    .cfg_targets, .pend_set, .pend_id,
    .ack_en(ack_fire), .ack_idx(best_idx), .eoi_en(eoi), .eoi_idx(eoi_id),
    .qualify, .group_o(group_v), .prio_o(prio_v)
  );

  irq_best_pick #(.NUM_SRC(NUM_SRC)) pick_i (
    .clk, .rst_n, .qualify, .group_i(group_v), .prio_i(prio_v),
    .bp(bp_q), .abp(abp_q), .cbpr, .best_valid, .best_idx, .best_gprio
  );

  irq_binpt_regs #(.BPR_MIN(BPR_MIN), .ABPR_MIN(ABPR_MIN)) bp_i (
    .clk, .rst_n, .wr_en(bp_we), .secure(reg_secure), .cbpr,
    .wdata(reg_wdata[2:0]), .bp_q, .abp_q, .ns_view
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        running_q <= IDLE_RUN;
    else if (ack_fire) running_q <= {1'b0, best_gprio};
    else if (eoi)      running_q <= IDLE_RUN;
  end

  assign ack_id   = best_valid ? 10'(best_idx) : SPURIOUS_ID;
  assign irq_out  = cpu_en && best_valid && ({1'b0, best_gprio} < running_q);
  assign rpr_view = (!LEGACY_REV && running_q[8]) ? 8'hFF : running_q[7:0];
  assign reg_rdata = (reg_sel == REG_RUNPRI) ? rpr_view
                   : {5'b0, (reg_secure ? bp_q : ns_view)};

  // R2: the spurious ID appears whenever nothing is selected
  assert_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !best_valid |-> ack_id == SPURIOUS_ID);
  // R6: no request while the interface is disabled
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (cpu_en && running_q != 9'h000));
  // R7: acknowledge loads the winner's group priority
  assert_ack_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> running_q == {1'b0, $past(best_gprio)});
  // R8: completion without acknowledge returns to idle
  assert_eoi_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_fire) |=> running_q == IDLE_RUN);
endmodule

// File: tb/irq_cpu_slice_tb_top.sv
module irq_cpu_slice_tb_top;
  localparam int NS = 48;
  localparam int SW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_en = 0, cbpr = 0, cfg_we = 0, cfg_enable = 0, cfg_group = 0;
  logic [SW-1:0] cfg_id = '0, pend_id = '0, eoi_id = '0;
  logic [7:0] cfg_prio = '0, reg_wdata = '0, reg_rdata;
  logic [7:0] cfg_targets = '0;
  logic pend_set = 0, ack = 0, eoi = 0, irq_out;
  logic reg_sel = 0, reg_secure = 0, reg_we = 0;
  logic [9:0] ack_id;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_cpu_slice dut_i (.*);

  // model state
  bit m_en[NS], m_pend[NS], m_act[NS], m_grp[NS];
  int m_pri[NS], m_tgt[NS];
  int m_bp = 2, m_abp = 3, m_run = 256;

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit qual(int i);
    return m_en[i] && m_pend[i] && !m_act[i] && (i < 32 || m_tgt[i][0]);
  endfunction
  function automatic int best();
    int b = 1023, bp = 256;
    for (int i = 0; i < NS; i++)
      if (qual(i) && m_pri[i] < bp) begin b = i; bp = m_pri[i]; end
    return b;
  endfunction
  function automatic int gprio(int i);
    int b = (m_grp[i] && !cbpr) ? m_abp - 1 : m_bp;
    return m_pri[i] & ((32'hFF << (b + 1)) & 32'hFF);
  endfunction
  function automatic int ns_bp();
    if (cbpr) return (m_bp == 7) ? 7 : m_bp + 1;
    return m_abp;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
    cfg_we = 0; pend_set = 0; ack = 0; eoi = 0; reg_we = 0;
  endtask

  task automatic cfg(int id, bit en, bit grp, int pri, int tgt);
    cfg_id = SW'(id); cfg_enable = en; cfg_group = grp;
    cfg_prio = 8'(pri); cfg_targets = 8'(tgt); cfg_we = 1; tick();
    m_en[id] = en; m_grp[id] = grp; m_pri[id] = pri; m_tgt[id] = tgt;
  endtask
  task automatic pend(int id);
    pend_id = SW'(id); pend_set = 1; tick(); m_pend[id] = 1;
  endtask
  task automatic do_ack();
    int b = best();
    chk("R7 ack id", int'(ack_id), b);
    ack = 1;
    if (b != 1023) begin
      m_run = gprio(b); m_act[b] = 1; m_pend[b] = 0;
    end
    tick();
  endtask
  task automatic do_eoi(int id);
    eoi_id = SW'(id); eoi = 1; tick(); m_act[id] = 0; m_run = 256;
  endtask
  task automatic bp_write(bit sec, int v);
    reg_sel = 0; reg_secure = sec; reg_wdata = 8'(v); reg_we = 1; tick();
    if (sec) m_bp = ((v & 7) < 2) ? 2 : (v & 7);
    else if (!cbpr) m_abp = ((v & 7) < 3) ? 3 : (v & 7);
  endtask

  task automatic check_all();
    int b;
    #1;
    b = best();
    chk("R4 selection", int'(ack_id), b);
    chk("R6 irq", int'(irq_out),
        int'(cpu_en && b != 1023 && gprio(b) < m_run));
    reg_sel = 1; #1;
    chk("R9 running prio", int'(reg_rdata), (m_run > 255) ? 255 : m_run);
    reg_sel = 0; reg_secure = 1; #1;
    chk("R10 secure bp", int'(reg_rdata), m_bp);
    reg_secure = 0; #1;
    chk("R10 ns bp", int'(reg_rdata), ns_bp());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7141));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 ack id", int'(ack_id), 1023);
    chk("R1 irq", int'(irq_out), 0);
    check_all();

    // R2 enabled but not pending
    cfg(5, 1, 0, 8'h40, 0);
    chk("R2 spurious", int'(ack_id), 1023);
    // R3 external with foreign target
    cfg(40, 1, 0, 8'h10, 8'h02);
    pend(40); #1;
    chk("R3 foreign target", int'(ack_id), 1023);
    cfg(40, 1, 0, 8'h10, 8'h01); #1;
    chk("R3 own target", int'(ack_id), 40);
    // R4 tie goes to lower ID
    cfg(5, 1, 0, 8'h10, 0);
    pend(5); #1;
    chk("R4 tie", int'(ack_id), 5);
    // R6 enable gating
    chk("R6 disabled", int'(irq_out), 0);
    cpu_en = 1; #1;
    chk("R6 enabled", int'(irq_out), 1);
    check_all();
    // R7 acknowledge, R13 re-pend while active
    do_ack();
    reg_sel = 1; #1;
    chk("R7 running", int'(reg_rdata), 8'h10);
    chk("R6 equal not preempt", int'(irq_out), 0);
    pend(5); #1;
    chk("R13 active excluded", int'(ack_id), 40);
    do_eoi(5); #1;
    reg_sel = 1; #1;
    chk("R8 idle", int'(reg_rdata), 255);
    chk("R8 back to 5", int'(ack_id), 5);
    do_ack(); do_eoi(5);
    // R5 group-1 uses aliased binary point minus one
    cfg(40, 1, 1, 8'h1C, 1); #1;
    do_ack();
    reg_sel = 1; #1;
    chk("R5 group1 abp-1", int'(reg_rdata), 8'h18);
    do_eoi(40);
    pend(40); cbpr = 1;
    bp_write(1, 4); #1;
    do_ack();
    reg_sel = 1; #1;
    chk("R5 shared mode", int'(reg_rdata), 8'h00);
    do_eoi(40);
    // R11 ignored write in shared mode, R10 saturation, R12 clamp
    bp_write(0, 1);
    cbpr = 0; reg_sel = 0; reg_secure = 0; #1;
    chk("R11 ignored", int'(reg_rdata), 3);
    bp_write(0, 0); #1;
    chk("R11 clamp", int'(reg_rdata), 3);
    bp_write(0, 6); #1;
    chk("R11 store", int'(reg_rdata), 6);
    bp_write(1, 7); cbpr = 1; reg_sel = 0; reg_secure = 0; #1;
    chk("R10 saturate", int'(reg_rdata), 7);
    bp_write(1, 8'hF8); reg_secure = 1; #1;
    chk("R12 clamp", int'(reg_rdata), 2);
    cbpr = 0;
    check_all();

    // random mix
    for (int k = 0; k < 600; k++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0, 1: cfg($urandom_range(0, NS-1), $urandom_range(0, 3) != 0,
                  1'($urandom_range(0, 1)), $urandom_range(0, 7) * 32 + $urandom_range(0, 3),
                  $urandom_range(0, 255));
        2, 3, 4: pend($urandom_range(0, NS-1));
        5: do_ack();
        6: begin
          int id = $urandom_range(0, NS-1);
          for (int j = 0; j < NS; j++) if (m_act[j]) id = j;
          do_eoi(id);
        end
        7: bp_write(1'($urandom_range(0, 1)), $urandom_range(0, 255));
        8: cbpr = 1'($urandom_range(0, 1));
        default: cpu_en = 1'($urandom_range(0, 3) != 0);
      endcase
      check_all();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule